// File: doc/BRIEF.md
# Device access permission controller

This block guards a group of peripheral slaves. Firmware programs it through a simple word-wide register port. The settings say which domain each bus master belongs to, whether a master always issues secure traffic, how each master domain maps into a local domain view, and a 2-bit permission for every pair of local domain and slave. For each request the block takes the master index, slave index, write flag and security flag. In the same cycle it returns a single grant bit, which the bus fabric uses to pass or reject the access.

A request is resolved in a fixed chain. The master index selects a 4-bit domain. The domain selects a 3-bit local domain from the remap table. The local domain selects a permission bank, and the slave index selects a 2-bit code inside that bank. The code is then weighed against the effective security of the request (the request flag OR the master's forced-secure bit) and its direction. A global enable opens every access while it is clear, so firmware can fill the tables before protection takes effect.

Top module: `dev_access_guard`

## Requirements
- R1: After reset every register reads zero, the block is disabled, and every request is granted.
- R2: The control register at 0xF00 stores bit 0 (enable) and bit 31; all other bits read zero, so writing 0x80000001 reads back 0x80000001. While bit 0 is clear every request is granted, whatever the tables hold.
- R3: With the block enabled, a permission code is decoded as follows: 0 grants. 3 denies. 1 grants only secure requests. 2 grants secure requests and non-secure reads, and denies non-secure writes.
- R4: Permission words hold 16 slaves at 2 bits each. Slave k is at byte offset 4*(k/16), bits 2*(k%16)+1:2*(k%16). Local domain b uses the bank starting at 0x100*b, for b from 0 to 7.
- R5: Master domains are 4-bit fields in words at 0xA00+4*(m/8), bits 4*(m%8)+3:4*(m%8).
- R6: Forced-secure bits sit in words at 0xB00+4*(m/32), bit m%32. A set bit makes that master's requests secure even when the request flag is low.
- R7: The remap register at 0xD00 holds the 3-bit local domain of domain d (0..9) at bits 3d+2:3d. Domain 10 has its low 2 bits at 0xD00 bits 31:30 and its top bit at 0xD04 bit 0. Domain d from 11 to 15 sits at 0xD04 bits 3(d-11)+3:3(d-11)+1, and 0xD04 bits 31:16 read zero.
- R8: Slaves have indices 0..195. Permission bits for indices above 195 are dropped on write and read zero. While the block is enabled, a request to such a slave is denied.
- R9: Register writes take effect at the next clock edge; a read returns the stored fields in the same cycle. Unmapped or misaligned addresses read zero and ignore writes.
- R10: The grant output is a combinational function of the request inputs and the current register state, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_master_i | input | 5 | Index of the requesting master |
| req_slave_i | input | 8 | Index of the target slave |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_secure_i | input | 1 | Security flag carried by the request |
| grant_o | output | 1 | 1 when the request is allowed |

## Verification
Directed patterns first place a forbidding code while the block is disabled and then enable it, which separates the enable gate from the table lookup. A code 1 and a code 2 slave are then hit with each mix of secure and write flags, which tells apart the four code meanings. Masters with non-zero domains are routed through remap entries that sit inside one register, across the two-register split and in the second register. In each case a second master hitting the same slave shows that the bank selection and not the slave code decided the result. A long random phase mixes register writes (valid, out-of-bank, unmapped) with random requests, including slave indices past the last one, and compares grant and read data against a behavioural model on every clock.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 12;
  localparam int PERM_W       = 2;
  localparam int DOM_W        = 4;
  localparam int LDOM_W       = 3;
  localparam int SLV_PER_WORD = DATA_W / PERM_W;
  localparam int MST_PER_WORD = DATA_W / DOM_W;
  localparam int SEC_PER_WORD = DATA_W;
  localparam int N_DOMAINS    = 1 << DOM_W;
  localparam int REMAP_W      = N_DOMAINS * LDOM_W;

  localparam logic [3:0]        MDOM_PAGE = 4'hA;
  localparam logic [3:0]        MSEC_PAGE = 4'hB;
  localparam logic [ADDR_W-1:0] RMP_LO_ADDR = 12'hD00;
  localparam logic [ADDR_W-1:0] RMP_HI_ADDR = 12'hD04;
  localparam logic [ADDR_W-1:0] CTRL_ADDR   = 12'hF00;

  typedef enum logic [PERM_W-1:0] {
    PERM_OPEN      = 2'd0,
    PERM_SEC_ONLY  = 2'd1,
    PERM_SEC_NS_RD = 2'd2,
    PERM_BLOCKED   = 2'd3
  } perm_e;
endpackage

// File: rtl/dag_regs.sv
module dag_regs
  import dag_pkg::*;
#(
  parameter int N_MASTERS = 32,
  parameter int N_SLAVES  = 196,
  parameter int N_BANKS   = 8,
  parameter int N_WORDS   = (N_SLAVES + SLV_PER_WORD - 1) / SLV_PER_WORD,
  parameter int N_ENT     = N_BANKS * N_WORDS
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic                              en_o,
  output logic [DATA_W-1:0]                 perm_o [N_ENT],
  output logic [N_MASTERS-1:0][DOM_W-1:0]   mdom_o,
  output logic [N_MASTERS-1:0]              msec_o,
  output logic [REMAP_W-1:0]                remap_o
);
  localparam int N_MW  = (N_MASTERS + MST_PER_WORD - 1) / MST_PER_WORD;
  localparam int N_SW  = (N_MASTERS + SEC_PER_WORD - 1) / SEC_PER_WORD;
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int HI_W  = REMAP_W - DATA_W;

  logic [DATA_W-1:0]             perm_q [N_ENT];
  logic [N_MASTERS-1:0][DOM_W-1:0] mdom_q;
  logic [N_MASTERS-1:0]          msec_q;
  logic [REMAP_W-1:0]            remap_q;
  logic                          en_q, top_q;

  logic [3:0]       a_page;
  logic [5:0]       a_word;
  logic             aligned;
  logic             perm_hit, mdom_hit, msec_hit, rlo_hit, rhi_hit, ctrl_hit, any_hit;
  logic [IDX_W-1:0] perm_idx;

  function automatic logic [DATA_W-1:0] word_mask(input int w);
    int cnt;
    cnt = N_SLAVES - SLV_PER_WORD * w;
    if (cnt >= SLV_PER_WORD) return '1;
    if (cnt <= 0) return '0;
    return (DATA_W'(1) << (PERM_W * cnt)) - DATA_W'(1);
  endfunction

  assign a_page  = addr_i[11:8];
  assign a_word  = addr_i[7:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    perm_hit = aligned && (int'(a_page) < N_BANKS) && (int'(a_word) < N_WORDS);
    mdom_hit = aligned && (a_page == MDOM_PAGE) && (int'(a_word) < N_MW);
    msec_hit = aligned && (a_page == MSEC_PAGE) && (int'(a_word) < N_SW);
    rlo_hit  = (addr_i == RMP_LO_ADDR);
    rhi_hit  = (addr_i == RMP_HI_ADDR);
    ctrl_hit = (addr_i == CTRL_ADDR);
    any_hit  = perm_hit | mdom_hit | msec_hit | rlo_hit | rhi_hit | ctrl_hit;
    perm_idx = perm_hit ? IDX_W'(int'(a_page) * N_WORDS + int'(a_word)) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) perm_q[i] <= '0;
      mdom_q  <= '0;
      msec_q  <= '0;
      remap_q <= '0;
      en_q    <= 1'b0;
      top_q   <= 1'b0;
    end else if (we_i) begin
      if (perm_hit) perm_q[perm_idx] <= wdata_i & word_mask(int'(a_word));
      if (mdom_hit) begin
        for (int m = 0; m < N_MASTERS; m++)
          if (m / MST_PER_WORD == int'(a_word))
            mdom_q[m] <= wdata_i[DOM_W*(m%MST_PER_WORD) +: DOM_W];
      end
      if (msec_hit) begin
        for (int m = 0; m < N_MASTERS; m++)
          if (m / SEC_PER_WORD == int'(a_word))
            msec_q[m] <= wdata_i[m%SEC_PER_WORD];
      end
      if (rlo_hit) remap_q[DATA_W-1:0] <= wdata_i;
      if (rhi_hit) remap_q[REMAP_W-1:DATA_W] <= wdata_i[HI_W-1:0];
      if (ctrl_hit) begin
        en_q  <= wdata_i[0];
        top_q <= wdata_i[DATA_W-1];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (perm_hit) begin
      rdata_o = perm_q[perm_idx];
    end else if (mdom_hit) begin
      for (int m = 0; m < N_MASTERS; m++)
        if (m / MST_PER_WORD == int'(a_word))
          rdata_o[DOM_W*(m%MST_PER_WORD) +: DOM_W] = mdom_q[m];
    end else if (msec_hit) begin
      for (int m = 0; m < N_MASTERS; m++)
        if (m / SEC_PER_WORD == int'(a_word))
          rdata_o[m%SEC_PER_WORD] = msec_q[m];
    end else if (rlo_hit) begin
      rdata_o = remap_q[DATA_W-1:0];
    end else if (rhi_hit) begin
      rdata_o = DATA_W'(remap_q[REMAP_W-1:DATA_W]);
    end else if (ctrl_hit) begin
      rdata_o = {top_q, {(DATA_W-2){1'b0}}, en_q};
    end
  end

  assign perm_o  = perm_q;
  assign mdom_o  = mdom_q;
  assign msec_o  = msec_q;
  assign remap_o = remap_q;
  assign en_o    = en_q;

  // R9
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && ctrl_hit) |=> $stable(en_q) && $stable(top_q));

  // R9
  remap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (rlo_hit || rhi_hit)) |=> $stable(remap_q));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_hit |-> (rdata_o == '0));
endmodule

// File: rtl/dag_dom_map.sv
module dag_dom_map
  import dag_pkg::*;
#(
  parameter int N_MASTERS = 32,
  parameter int MST_W     = 5
) (
  input  logic [MST_W-1:0]               master_i,
  input  logic                           secure_i,
  input  logic [N_MASTERS-1:0][DOM_W-1:0] mdom_i,
  input  logic [N_MASTERS-1:0]           msec_i,
  input  logic [REMAP_W-1:0]             remap_i,
  output logic [LDOM_W-1:0]              ldom_o,
  output logic                           sec_eff_o
);
  logic             mst_ok;
  logic [DOM_W-1:0] dom;

  always_comb begin
    mst_ok    = (int'(master_i) < N_MASTERS);
    dom       = mst_ok ? mdom_i[master_i] : '0;
    sec_eff_o = secure_i | (mst_ok & msec_i[master_i]);
    // one flat vector: domain 10 straddles both remap words for free
    ldom_o    = remap_i[LDOM_W*int'(dom) +: LDOM_W];
  end
endmodule

// File: rtl/dag_perm_check.sv
module dag_perm_check
  import dag_pkg::*;
#(
  parameter int N_SLAVES = 196,
  parameter int N_BANKS  = 8,
  parameter int SLV_W    = 8,
  parameter int N_WORDS  = (N_SLAVES + SLV_PER_WORD - 1) / SLV_PER_WORD,
  parameter int N_ENT    = N_BANKS * N_WORDS
) (
  input  logic                en_i,
  input  logic [DATA_W-1:0]   perm_i [N_ENT],
  input  logic [LDOM_W-1:0]   ldom_i,
  input  logic [SLV_W-1:0]    slave_i,
  input  logic                write_i,
  input  logic                sec_eff_i,
  output perm_e               code_o,
  output logic                range_ok_o,
  output logic                grant_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sel;
  logic              allow;

  always_comb begin
    range_ok_o = (int'(slave_i) < N_SLAVES) && (int'(ldom_i) < N_BANKS);
    idx = range_ok_o ?
          IDX_W'(int'(ldom_i) * N_WORDS + int'(slave_i) / SLV_PER_WORD) : '0;
    sel    = perm_i[idx];
    code_o = perm_e'(sel[PERM_W*(int'(slave_i) % SLV_PER_WORD) +: PERM_W]);
    unique case (code_o)
      PERM_OPEN:      allow = 1'b1;
      PERM_SEC_ONLY:  allow = sec_eff_i;
      PERM_SEC_NS_RD: allow = sec_eff_i | ~write_i;
      default:        allow = 1'b0;
    endcase
    grant_o = ~en_i | (range_ok_o & allow);
  end
endmodule

// File: rtl/dev_access_guard.sv
module dev_access_guard
  import dag_pkg::*;
#(
  parameter int N_MASTERS = 32,
  parameter int N_SLAVES  = 196,
  parameter int N_BANKS   = 8,
  parameter int SLV_W     = 8,
  parameter int MST_W     = $clog2(N_MASTERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [MST_W-1:0]  req_master_i,
  input  logic [SLV_W-1:0]  req_slave_i,
  input  logic              req_write_i,
  input  logic              req_secure_i,
  output logic              grant_o
);
  localparam int N_WORDS = (N_SLAVES + SLV_PER_WORD - 1) / SLV_PER_WORD;
  localparam int N_ENT   = N_BANKS * N_WORDS;

  logic                            ctrl_en;
  logic [DATA_W-1:0]               perm [N_ENT];
  logic [N_MASTERS-1:0][DOM_W-1:0] mdom;
  logic [N_MASTERS-1:0]            msec;
  logic [REMAP_W-1:0]              remap;
  logic [LDOM_W-1:0]               ldom;
  logic                            sec_eff;
  perm_e                           code;
  logic                            range_ok;

  dag_regs #(
    .N_MASTERS(N_MASTERS), .N_SLAVES(N_SLAVES), .N_BANKS(N_BANKS),
    .N_WORDS(N_WORDS), .N_ENT(N_ENT)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (ctrl_en),
    .perm_o  (perm),
    .mdom_o  (mdom),
    .msec_o  (msec),
    .remap_o (remap)
  );

  dag_dom_map #(.N_MASTERS(N_MASTERS), .MST_W(MST_W)) u_dom (
    .master_i  (req_master_i),
    .secure_i  (req_secure_i),
    .mdom_i    (mdom),
    .msec_i    (msec),
    .remap_i   (remap),
    .ldom_o    (ldom),
    .sec_eff_o (sec_eff)
  );

  dag_perm_check #(
    .N_SLAVES(N_SLAVES), .N_BANKS(N_BANKS), .SLV_W(SLV_W),
    .N_WORDS(N_WORDS), .N_ENT(N_ENT)
  ) u_chk (
    .en_i       (ctrl_en),
    .perm_i     (perm),
    .ldom_i     (ldom),
    .slave_i    (req_slave_i),
    .write_i    (req_write_i),
    .sec_eff_i  (sec_eff),
    .code_o     (code),
    .range_ok_o (range_ok),
    .grant_o    (grant_o)
  );

  // R2
  open_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |-> grant_o);

  // R3
  blocked_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en && code == PERM_BLOCKED) |-> !grant_o);

  // R6
  forced_secure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en && range_ok && code != PERM_BLOCKED && int'(req_master_i) < N_MASTERS
     && msec[req_master_i]) |-> grant_o);

  // R8
  oob_slave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en && int'(req_slave_i) >= N_SLAVES) |-> !grant_o);
endmodule

// File: tb/sim_dev_access_guard.sv
`timescale 1ns/1ps
module sim_dev_access_guard;
  localparam int NM = 32;
  localparam int NS = 196;
  localparam int NB = 8;
  localparam int NW = (NS + 15) / 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  mst = '0;
  logic [7:0]  slv = '0;
  logic        wr = 1'b0;
  logic        sec = 1'b0;
  logic        grant;

  always #5 clk = ~clk;

  dev_access_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_master_i(mst),
    .req_slave_i(slv), .req_write_i(wr), .req_secure_i(sec), .grant_o(grant)
  );

  int  m_perm [NB][NS];
  int  m_dom  [NM];
  bit  m_sec  [NM];
  int  m_rmp  [16];
  bit  m_en, m_top;
  int  n_chk = 0, n_err = 0;
  bit  done = 0;

  task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  function automatic void mdl_write(logic [11:0] a, logic [31:0] d);
    int pg, w;
    pg = int'(a[11:8]); w = int'(a[7:2]);
    if (a[1:0] != 0) return;
    if (pg < NB && w < NW) begin
      for (int i = 0; i < 16; i++)
        if (w*16 + i < NS) m_perm[pg][w*16+i] = int'((d >> (2*i)) & 32'h3);
    end else if (pg == 10 && w < NM/8) begin
      for (int i = 0; i < 8; i++) m_dom[w*8+i] = int'((d >> (4*i)) & 32'hF);
    end else if (pg == 11 && w == 0) begin
      for (int i = 0; i < NM; i++) m_sec[i] = d[i];
    end else if (a == 12'hD00) begin
      for (int i = 0; i < 10; i++) m_rmp[i] = int'((d >> (3*i)) & 32'h7);
      m_rmp[10] = (m_rmp[10] & 4) | int'(d[31:30]);
    end else if (a == 12'hD04) begin
      m_rmp[10] = (m_rmp[10] & 3) | (int'(d[0]) << 2);
      for (int i = 11; i < 16; i++) m_rmp[i] = int'((d >> (3*(i-11)+1)) & 32'h7);
    end else if (a == 12'hF00) begin
      m_en = d[0]; m_top = d[31];
    end
  endfunction

  function automatic logic [31:0] mdl_read(logic [11:0] a);
    logic [31:0] r;
    int pg, w;
    r = 0; pg = int'(a[11:8]); w = int'(a[7:2]);
    if (a[1:0] != 0) return 0;
    if (pg < NB && w < NW) begin
      for (int i = 0; i < 16; i++)
        if (w*16 + i < NS) r |= 32'(m_perm[pg][w*16+i]) << (2*i);
    end else if (pg == 10 && w < NM/8) begin
      for (int i = 0; i < 8; i++) r |= 32'(m_dom[w*8+i]) << (4*i);
    end else if (pg == 11 && w == 0) begin
      for (int i = 0; i < NM; i++) r[i] = m_sec[i];
    end else if (a == 12'hD00) begin
      for (int i = 0; i < 10; i++) r |= 32'(m_rmp[i]) << (3*i);
      r |= 32'(m_rmp[10] & 3) << 30;
    end else if (a == 12'hD04) begin
      r |= 32'(m_rmp[10] >> 2);
      for (int i = 11; i < 16; i++) r |= 32'(m_rmp[i]) << (3*(i-11)+1);
    end else if (a == 12'hF00) begin
      r[0] = m_en; r[31] = m_top;
    end
    return r;
  endfunction

  function automatic bit mdl_grant(int m, int s, bit w, bit sc);
    int l, c;
    bit se;
    if (!m_en) return 1;
    if (s >= NS) return 0;
    l = m_rmp[m_dom[m]];
    if (l >= NB) return 0;
    c = m_perm[l][s];
    se = sc | m_sec[m];
    case (c)
      0: return 1;
      1: return se;
      2: return se | !w;
      default: return 0;
    endcase
  endfunction

  // one clock: drive at negedge, compare mid-cycle, model commits at posedge
  task automatic step(bit w_en, logic [11:0] a, logic [31:0] d,
                      int m, int s, bit w, bit sc, string rq);
    @(negedge clk);
    we = w_en; addr = a; wdata = d;
    mst = 5'(m); slv = 8'(s); wr = w; sec = sc;
    #1;
    chk({rq, " grant"}, 32'(grant), 32'(mdl_grant(m, s, w, sc)));
    chk({rq, " rdata"}, rdata, mdl_read(a));
    @(posedge clk);
    if (w_en) mdl_write(a, d);
  endtask

  task automatic peek(logic [11:0] a, logic [31:0] exp, string rq);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    chk({rq, " literal"}, rdata, exp);
  endtask

  task automatic req_lit(int m, int s, bit w, bit sc, bit exp, string rq);
    @(negedge clk);
    we = 1'b0; mst = 5'(m); slv = 8'(s); wr = w; sec = sc;
    #1;
    chk({rq, " literal grant"}, 32'(grant), 32'(exp));
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int s = 0; s < NS; s++) m_perm[b][s] = 0;
    for (int i = 0; i < NM; i++) begin m_dom[i] = 0; m_sec[i] = 0; end
    for (int i = 0; i < 16; i++) m_rmp[i] = 0;
    m_en = 0; m_top = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(12'hF00, 32'h0, "R1");
    peek(12'hD00, 32'h0, "R1");
    step(0, 12'h000, 0, 7, 1, 1, 0, "R1");

    // R2 forbid slave 1 while disabled, then enable
    step(1, 12'h000, 32'hC, 0, 1, 1, 0, "R2");
    req_lit(0, 1, 1, 0, 1'b1, "R2");
    step(1, 12'hF00, 32'h8000_0001, 0, 1, 0, 0, "R2");
    peek(12'hF00, 32'h8000_0001, "R2");
    req_lit(0, 1, 0, 1, 1'b0, "R3");

    // R3 slave2 code 1, slave3 code 2
    step(1, 12'h000, 32'h9C, 0, 0, 0, 0, "R3");
    req_lit(0, 2, 0, 0, 1'b0, "R3");
    req_lit(0, 2, 1, 1, 1'b1, "R3");
    req_lit(0, 3, 0, 0, 1'b1, "R3");
    req_lit(0, 3, 1, 0, 1'b0, "R3");
    req_lit(0, 3, 1, 1, 1'b1, "R3");
    step(0, 12'h000, 0, 0, 0, 1, 0, "R3");

    // R4 R5 master 5 -> domain 1 -> bank 1, slave 37 forbidden there
    step(1, 12'hA00, 32'h0010_0000, 0, 0, 0, 0, "R5");
    step(1, 12'hD00, 32'h8, 0, 0, 0, 0, "R7");
    step(1, 12'h108, 32'hC00, 0, 0, 0, 0, "R4");
    req_lit(5, 37, 0, 1, 1'b0, "R4");
    req_lit(0, 37, 0, 1, 1'b1, "R4");
    step(0, 12'h108, 0, 5, 37, 0, 0, "R5");

    // R6 slave 38 code 1 in bank 1, then force master 5 secure
    step(1, 12'h108, 32'h1C00, 5, 38, 0, 0, "R6");
    req_lit(5, 38, 0, 0, 1'b0, "R6");
    step(1, 12'hB00, 32'h20, 5, 38, 0, 0, "R6");
    req_lit(5, 38, 1, 0, 1'b1, "R6");

    // R7 domain 10 straddles the two remap words
    step(1, 12'hA04, 32'hA0, 0, 0, 0, 0, "R7");
    step(1, 12'hD00, 32'h4000_0008, 0, 0, 0, 0, "R7");
    step(1, 12'hD04, 32'h1, 0, 0, 0, 0, "R7");
    step(1, 12'h500, 32'h3, 0, 0, 0, 0, "R7");
    req_lit(9, 0, 0, 1, 1'b0, "R7");
    req_lit(0, 0, 0, 0, 1'b1, "R7");
    step(1, 12'hD04, 32'h0, 9, 0, 0, 0, "R7");
    req_lit(9, 0, 0, 0, 1'b1, "R7");
    step(1, 12'hA04, 32'hBA0, 10, 0, 0, 0, "R7");
    step(1, 12'hD04, 32'hA, 10, 0, 0, 0, "R7");
    req_lit(10, 0, 0, 1, 1'b0, "R7");
    peek(12'hD04, 32'hA, "R7");

    // R8 bits past the last slave are dropped; out-of-range slave denied
    step(1, 12'h030, 32'hFFFF_FFFF, 0, 196, 0, 1, "R8");
    peek(12'h030, 32'h0000_00FF, "R8");
    req_lit(0, 200, 0, 1, 1'b0, "R8");

    // R9 unmapped and misaligned addresses
    step(1, 12'hE00, 32'hFFFF_FFFF, 0, 0, 0, 0, "R9");
    peek(12'hE00, 32'h0, "R9");
    step(1, 12'h002, 32'hFFFF_FFFF, 0, 0, 0, 0, "R9");
    peek(12'h000, 32'hFFFF_FF00 & 32'h0 | 32'h9C, "R9");
    // R9 write lands at the edge: old state seen in the write cycle
    step(1, 12'hF00, 32'h0, 10, 0, 0, 0, "R9");
    req_lit(10, 0, 0, 0, 1'b1, "R9");

    // R10 random mix compared every clock
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int k;
      k = int'($urandom_range(0, 11));
      d = $urandom;
      case (k)
        0, 1, 2: a = {1'b0, 3'($urandom_range(0, 7)), 6'($urandom_range(0, 15)), 2'b00};
        3:       a = 12'hA00 + 12'(4 * $urandom_range(0, 4));
        4:       a = 12'hB00 + 12'(4 * $urandom_range(0, 1));
        5:       a = 12'hD00;
        6:       a = 12'hD04;
        7:       begin a = 12'hF00; d[0] = ($urandom_range(0, 3) != 0); end
        8:       a = 12'(12'h800 + $urandom_range(0, 12'h7FF));
        default: a = {1'b0, 3'($urandom_range(0, 7)), 6'($urandom_range(0, 12)), 2'b00};
      endcase
      step(bit'($urandom_range(0, 1)), a, d, int'($urandom_range(0, NM-1)),
           int'($urandom_range(0, 205)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), "R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule